// File: doc/BRIEF.md
# Transmitter mode and clock-start controller

This block sequences a small UHF transmitter. Three control lines, ASK, FSK and an ENABLE line that can be driven low, driven high or left floating, are decoded combinationally into one of three modes: power-down, idle and power-up. From the mode and the two data lines it drives enables for the crystal oscillator, the PLL and the power amplifier, together with a control that closes the FSK capacitor switch. A floating ENABLE behaves as ASK OR FSK. Idle mode, selected by driving ENABLE low, keeps everything off so that the ASK and FSK lines can serve other devices on a shared three-wire bus.

After power-up the block waits for an amplitude-OK flag from the oscillator and passes it through a two-flop synchronizer. It then opens a gate onto the crystal clock divided by eight. The gate opens only at the point where the divided clock starts a low half, so the first CLK period is always complete. A lock-wait counter then runs for `LOCK_CYC` crystal cycles, after which a ready flag rises and data transmission may start. Leaving power-up, whether to power-down or to idle, returns the start-up state machine to its off state and clears the gate, the counter and the ready flag.

The start-up state machine has four states. ST_OFF moves to ST_AMP_WAIT on power-up. ST_AMP_WAIT moves to ST_LOCK_WAIT when the synchronized amplitude flag is high on the last divider phase. ST_LOCK_WAIT moves to ST_READY after `LOCK_CYC` cycles. Any state returns to ST_OFF when power-up ends.

Top module: `tx_mode_ctrl`

## Requirements
- R1: With ENABLE floating (`en_drv_i`=0, `en_lvl_i` ignored), the block is in power-up (`mode_o`=2'b10) when ASK or FSK is high, and in power-down otherwise.
- R2: With ASK=0, FSK=0 and ENABLE low or floating, `mode_o`=2'b00. Oscillator, PLL and amplifier enables are low and `fsk_sw_closed_o`=0 (switch open).
- R3: With ENABLE driven low (`en_drv_i`=1, `en_lvl_i`=0) and ASK or FSK high, `mode_o`=2'b01 (idle). All enables are low and `fsk_sw_closed_o`=0.
- R4: With ENABLE driven high and ASK=FSK=0, `mode_o`=2'b10. Oscillator and PLL enables are high, `pa_en_o`=0 and `fsk_sw_closed_o`=1.
- R5: In power-up, `pa_en_o` equals ASK. Outside power-up it is 0.
- R6: In power-up, `fsk_sw_closed_o` is the inverse of FSK. Outside power-up it is 0.
- R7: `clk_out_o` and `ready_o` are 0 during reset, outside power-up, and in power-up until `amp_ok_i` has passed the two-flop synchronizer. The gate opens between 3 and 10 clocks after `amp_ok_i` rises.
- R8: Once the gate opens, `clk_out_o` is the input clock divided by 8: 4 cycles low, then 4 cycles high, repeating. The first high pulse is a full 4 cycles.
- R9: `ready_o` rises exactly `LOCK_CYC` clocks after the gate opens, which is `LOCK_CYC`-4 clocks after the first rising edge of `clk_out_o`. It stays high while power-up lasts, regardless of ASK and FSK changes inside power-up.
- R10: One clock after power-up ends, `clk_out_o` and `ready_o` are 0. On a later power-up the lock wait restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ask_i | input | 1 | ASK control line; amplifier on when high in power-up |
| fsk_i | input | 1 | FSK control line; switch open when high |
| en_drv_i | input | 1 | ENABLE is driven (1) or floating (0) |
| en_lvl_i | input | 1 | ENABLE level when driven |
| amp_ok_i | input | 1 | Oscillator amplitude reached, asynchronous |
| mode_o | output | 2 | 00 power-down, 01 idle, 10 power-up |
| osc_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| pa_en_o | output | 1 | Power amplifier enable |
| fsk_sw_closed_o | output | 1 | FSK capacitor switch closed (low impedance) |
| clk_out_o | output | 1 | Gated clock, input clock divided by 8 |
| ready_o | output | 1 | PLL lock interval elapsed |

## Verification
The assertions assume that ASK, FSK and the two ENABLE bits change away from the clock edge and hold steady across each sampling edge. They also assume that `amp_ok_i` stays high for as long as the mode remains power-up, so that the gate-boundary and lock-ordering properties see a clean start sequence. The stimulus changes every input 2 ns after a rising edge and raises amplitude-OK only inside power-up. It also keeps `LOCK_CYC` small, so that every full start sequence, exit and restart fits in a short run.

// File: rtl/tx_ctrl_pkg.sv
package tx_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_PDOWN = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_PWRUP = 2'b10
    } tx_mode_e;

    typedef enum logic [1:0] {
        ST_OFF       = 2'b00,
        ST_AMP_WAIT  = 2'b01,
        ST_LOCK_WAIT = 2'b10,
        ST_READY     = 2'b11
    } start_st_e;

endpackage

// File: rtl/tx_mode_decode.sv
module tx_mode_decode
    import tx_ctrl_pkg::*;
(
    input  logic     ask,
    input  logic     fsk,
    input  logic     en_drv,
    input  logic     en_lvl,
    output tx_mode_e mode,
    output logic     pwr_up,
    output logic     pa_en,
    output logic     sw_closed
);

    logic any_line;

    always_comb begin
        any_line = ask | fsk;
        unique case ({en_drv, en_lvl})
            2'b00, 2'b01: mode = any_line ? MODE_PWRUP : MODE_PDOWN;
            2'b10:        mode = any_line ? MODE_IDLE  : MODE_PDOWN;
            2'b11:        mode = MODE_PWRUP;
            default:      mode = MODE_PDOWN;
        endcase
    end

    always_comb begin
        pwr_up    = (mode == MODE_PWRUP);
        pa_en     = pwr_up & ask;
        sw_closed = pwr_up & ~fsk;
    end

endmodule

// File: rtl/tx_amp_sync.sv
module tx_amp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/tx_clk_div.sv
module tx_clk_div #(
    parameter int DIV_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    output logic [DIV_LOG2-1:0] phase,
    output logic                phase_last,
    output logic                div_clk
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase <= '0;
        else if (!run) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    assign phase_last = &phase;
    assign div_clk    = phase[DIV_LOG2-1];

endmodule

// File: rtl/tx_start_fsm.sv
module tx_start_fsm
    import tx_ctrl_pkg::*;
#(
    parameter int LOCK_CYC = 3282,
    localparam int CNT_W   = $clog2(LOCK_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic amp_ok_s,
    input  logic phase_last,
    output logic gate,
    output logic ready
);

    start_st_e        state, state_nx;
    logic [CNT_W-1:0] lock_cnt;
    logic             lock_done;

    assign lock_done = (lock_cnt == CNT_W'(LOCK_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:       if (pwr_up) state_nx = ST_AMP_WAIT;
            ST_AMP_WAIT:  if (amp_ok_s && phase_last) state_nx = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (lock_done) state_nx = ST_READY;
            ST_READY:     state_nx = ST_READY;
            default:      state_nx = ST_OFF;
        endcase
        if (!pwr_up) state_nx = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     lock_cnt <= '0;
        else if (state == ST_LOCK_WAIT && pwr_up) lock_cnt <= lock_cnt + 1'b1;
        else                            lock_cnt <= '0;
    end

    always_comb begin
        gate  = 1'b0;
        ready = 1'b0;
        unique case (state)
            ST_OFF, ST_AMP_WAIT: ;
            ST_LOCK_WAIT:        gate = 1'b1;
            ST_READY: begin
                gate  = 1'b1;
                ready = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    pdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> (state == ST_OFF && lock_cnt == '0));

    // R9
    ready_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (gate && $past(gate)));

endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
    import tx_ctrl_pkg::*;
#(
    parameter int LOCK_CYC    = 3282,
    parameter int DIV_LOG2    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_xtal,
    input  logic       rst_n,
    input  logic       ask_i,
    input  logic       fsk_i,
    input  logic       en_drv_i,
    input  logic       en_lvl_i,
    input  logic       amp_ok_i,
    output logic [1:0] mode_o,
    output logic       osc_en_o,
    output logic       pll_en_o,
    output logic       pa_en_o,
    output logic       fsk_sw_closed_o,
    output logic       clk_out_o,
    output logic       ready_o
);

    tx_mode_e            mode;
    logic                pwr_up;
    logic                amp_s;
    logic [DIV_LOG2-1:0] phase;
    logic                phase_last;
    logic                div_clk;
    logic                gate;

    tx_mode_decode u_dec (
        .ask       (ask_i),
        .fsk       (fsk_i),
        .en_drv    (en_drv_i),
        .en_lvl    (en_lvl_i),
        .mode      (mode),
        .pwr_up    (pwr_up),
        .pa_en     (pa_en_o),
        .sw_closed (fsk_sw_closed_o)
    );

    tx_amp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_xtal),
        .rst_n   (rst_n),
        .d_async (amp_ok_i & pwr_up),
        .q_sync  (amp_s)
    );

    tx_clk_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk        (clk_xtal),
        .rst_n      (rst_n),
        .run        (pwr_up),
        .phase      (phase),
        .phase_last (phase_last),
        .div_clk    (div_clk)
    );

    tx_start_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
        .clk        (clk_xtal),
        .rst_n      (rst_n),
        .pwr_up     (pwr_up),
        .amp_ok_s   (amp_s),
        .phase_last (phase_last),
        .gate       (gate),
        .ready      (ready_o)
    );

    assign mode_o    = mode;
    assign osc_en_o  = pwr_up;
    assign pll_en_o  = pwr_up;
    assign clk_out_o = gate & div_clk;

    // R8
    gate_at_boundary_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        $rose(gate) |-> (phase == '0));

    // R10
    clk_off_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !osc_en_o |=> (!clk_out_o && !ready_o));

    // R5
    pa_needs_pwr_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        pa_en_o |-> (osc_en_o && pll_en_o));

    // R3
    idle_quiet_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (!osc_en_o && !pa_en_o && !fsk_sw_closed_o));

endmodule

// File: tb/tb_tx_mode_ctrl.sv
`timescale 1ns/1ps
module tb_tx_mode_ctrl;

    localparam int LOCK = 20;
    localparam int NV   = 12;
    // {ask, fsk, en_drv, en_lvl, mode[1:0], osc, pa, sw}
    localparam logic [8:0] VEC [NV] = '{
        9'b0000_00_000, 9'b0100_10_100, 9'b1000_10_111, 9'b1100_10_110,
        9'b0010_00_000, 9'b0110_01_000, 9'b1010_01_000, 9'b1110_01_000,
        9'b0011_10_101, 9'b0111_10_100, 9'b1011_10_111, 9'b1111_10_110
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ask = 0, fsk = 0, drv = 0, lvl = 0, amp = 0;
    logic [1:0] mode;
    logic osc, pll, pa, sw, clk_out, ready;
    int n_chk = 0, n_bad = 0;
    logic hist_c [48];
    logic hist_r [48];

    always #4 clk = ~clk;

    tx_mode_ctrl #(.LOCK_CYC(LOCK)) dut (
        .clk_xtal(clk), .rst_n(rst_n), .ask_i(ask), .fsk_i(fsk),
        .en_drv_i(drv), .en_lvl_i(lvl), .amp_ok_i(amp), .mode_o(mode),
        .osc_en_o(osc), .pll_en_o(pll), .pa_en_o(pa), .fsk_sw_closed_o(sw),
        .clk_out_o(clk_out), .ready_o(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int t_rise, t_ready, bad;
        // reset with inputs asking for power-up
        fsk = 1; amp = 1;
        repeat (4) tick();
        check(!clk_out && !ready, "R7 reset state", {clk_out, ready}, 0);
        fsk = 0; amp = 0;
        rst_n = 1;
        tick();

        // vector table for the decode
        for (int i = 0; i < NV; i++) begin
            logic [8:0] v;
            string tag;
            v = VEC[i];
            {ask, fsk, drv, lvl} = v[8:5];
            #1;
            if (!drv)      tag = (v[8] | v[7]) ? "R1 R5 R6" : "R1 R2";
            else if (!lvl) tag = (v[8] | v[7]) ? "R3" : "R2";
            else           tag = (v[8] | v[7]) ? "R5 R6" : "R4";
            check({mode, osc, pa, sw} == v[4:0] && pll == v[2], tag,
                  {mode, osc, pll, pa, sw}, {v[4:2], v[2], v[1:0]});
            tick();
        end

        // start-up through floating ENABLE, FSK high
        ask = 0; fsk = 1; drv = 0; lvl = 0; amp = 0;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (clk_out || ready) bad = 1;
        end
        check(bad == 0, "R7 clk held low before amp_ok", bad, 0);

        amp = 1;
        for (int i = 0; i < 48; i++) begin
            tick();
            hist_c[i] = clk_out;
            hist_r[i] = ready;
        end
        t_rise = -1;
        for (int i = 47; i >= 0; i--) if (hist_c[i]) t_rise = i;
        check(t_rise >= 6 && t_rise <= 13, "R7 gate latency", t_rise, 6);
        if (t_rise >= 6 && t_rise <= 13) begin
            bad = 0;
            for (int k = 0; k < 4; k++) begin
                if (!hist_c[t_rise + k]) bad = 1;
                if (hist_c[t_rise + 4 + k]) bad = 1;
                if (!hist_c[t_rise + 8 + k]) bad = 1;
            end
            check(bad == 0, "R8 full first period and divide by 8", bad, 0);
            check(!hist_r[t_rise + LOCK - 5] && hist_r[t_rise + LOCK - 4],
                  "R9 ready timing", {hist_r[t_rise + LOCK - 5], hist_r[t_rise + LOCK - 4]}, 1);
        end

        // ASK keying while ready
        ask = 1; #1;
        check(pa && ready, "R5 amplifier follows ASK, ready held", {pa, ready}, 3);
        tick(); ask = 0; fsk = 0; drv = 1; lvl = 1; #1;
        check(!pa && sw && ready, "R6 R9 switch closes, ready held", {pa, sw, ready}, 1);

        // exit to power-down
        drv = 0; tick();
        check(!clk_out && !ready && !osc, "R10 power-down clears", {clk_out, ready, osc}, 0);
        fsk = 1; repeat (5) tick();
        check(!ready, "R10 lock wait restarts", ready, 0);
        t_ready = -1;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (ready && t_ready < 0) t_ready = i;
        end
        check(t_ready >= 0, "R9 ready after restart", t_ready, 0);

        // exit to idle
        drv = 1; lvl = 0; tick();
        check(!clk_out && !ready && mode == 2'b01, "R3 R10 idle clears",
              {clk_out, ready, mode}, 1);
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (clk_out || ready || osc || pa) bad = 1;
        end
        check(bad == 0, "R3 idle stays quiet", bad, 0);

        finish_run();
    end

endmodule